// File: doc/BRIEF.md
# Per-Channel Bank Select and Synchronous Load Unit

This block feeds the final output registers of a 32-channel converter array. Every channel receives two calibrated candidate values, one from bank A and one from bank B. A per-channel select bit decides which of the two the channel's output register takes when an update happens. The select bits are grouped eight to a register, one register per group of eight channels. The host can write each group register on its own, or set all 32 bits to the same value with one broadcast command.

Updates are controlled by an active-low load pin. The pin is asynchronous, so it passes through a two-flop synchronizer first. While the synchronized pin is low, every output register reloads from its selected source on every clock. While it is high, all outputs hold. If the pin is tied low, the outputs follow the calibrated data as it changes. The host cannot read or write the output registers directly. A new select value therefore reaches the outputs only through a load.

Top module: `bank_select_load`

## Requirements
- R1: After reset, every channel output is 0x8000 and every select bit is 0.
- R2: A host write with group index g (0 to 3) and an 8-bit value stores that value in group g's select register. Bit k of that register controls channel 8*g+k.
- R3: During a load, a channel whose select bit is 0 takes its bank-A value, and a channel whose select bit is 1 takes its bank-B value. Channel c occupies bits [16*c+15:16*c] of the output bus and of both bank buses.
- R4: The broadcast command sets all 32 select bits to the level of its value input.
- R5: If the broadcast command and a group write occur in the same cycle, the broadcast wins and the group write is dropped.
- R6: The load pin passes through two flops. A low level first sampled at rising edge n updates the outputs at edge n+2, and all channels update on the same edge.
- R7: While the synchronized load level is high, the outputs hold their values. Changes to the banks and to the select bits in that time are not visible at the outputs.
- R8: While the load pin stays low, the outputs take new bank values on the first rising edge after those values appear.
- R9: A select write in a cycle with an active load does not affect the update on that edge. That update uses the previous select bits, and the new bits apply from the next load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankAIn | input | 512 | Bank-A calibrated values, 16 bits per channel |
| bankBIn | input | 512 | Bank-B calibrated values, 16 bits per channel |
| selWrEn | input | 1 | Group select-register write strobe |
| selWrGroup | input | 2 | Group index for the write |
| selWrData | input | 8 | Select bits for the addressed group |
| setAllEn | input | 1 | Broadcast command strobe for all select bits |
| setAllVal | input | 1 | Level applied to every select bit by the broadcast |
| loadN | input | 1 | Active-low asynchronous load level |
| dacOut | output | 512 | Output register values, 16 bits per channel |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a group write and the broadcast command. The bench drives both strobes in one cycle and then runs a load, and every channel must show the broadcast level. The second pair is a select write and an active load. With the load pin held low, the bench writes a group register on a single edge. On that edge the outputs must still reflect the old select bits, and on the following edge they must reflect the new ones. The bench also sweeps all 256 select values in every group and computes each channel's expected output from its bit.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef struct packed {
    logic loadNow;
    logic setAll;
    logic setVal;
    logic selWrite;
  } bsl_strobe_t;
endpackage

// File: rtl/bsl_ctrl.sv
module bsl_ctrl
  import bsl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadN,
  input  logic        selWrEn,
  input  logic        setAllEn,
  input  logic        setAllVal,
  output bsl_strobe_t strb
);
  logic [1:0] loadSync;

  always_ff @(posedge clk) begin
    if (!rstN) loadSync <= 2'b11;
    else       loadSync <= {loadSync[0], loadN};
  end

  always_comb begin
    strb.loadNow  = ~loadSync[1];
    strb.setAll   = setAllEn;
    strb.setVal   = setAllVal;
    strb.selWrite = selWrEn & ~setAllEn;
  end

  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadNow |-> ($past(loadN, 2) == 1'b0)) else $error("load latency"); // R6
endmodule

// File: rtl/bsl_datapath.sv
module bsl_datapath
  import bsl_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 8,
  parameter int DATA_W     = 16,
  parameter int GRP_IDX_W  = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  bsl_strobe_t                           strb,
  input  logic [GRP_IDX_W-1:0]                  wrGroup,
  input  logic [GROUP_W-1:0]                    wrData,
  input  logic [NUM_GROUPS*GROUP_W*DATA_W-1:0]  bankA,
  input  logic [NUM_GROUPS*GROUP_W*DATA_W-1:0]  bankB,
  output logic [NUM_GROUPS*GROUP_W*DATA_W-1:0]  outBus
);
  localparam int NUM_CH = NUM_GROUPS * GROUP_W;
  localparam logic [DATA_W-1:0] RESET_CODE = DATA_W'(1) << (DATA_W - 1);

  logic [GROUP_W-1:0] selReg [NUM_GROUPS];
  logic [DATA_W-1:0]  outReg [NUM_CH];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gSel
    always_ff @(posedge clk) begin
      if (!rstN)                                     selReg[g] <= '0;
      else if (strb.setAll)                          selReg[g] <= {GROUP_W{strb.setVal}};
      else if (strb.selWrite && wrGroup == GRP_IDX_W'(g)) selReg[g] <= wrData;
    end

    AST_SET_ALL: assert property (@(posedge clk) disable iff (!rstN)
      strb.setAll |=> (selReg[g] == {GROUP_W{$past(strb.setVal)}})) else $error("set all"); // R4
    AST_GROUP_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (strb.selWrite && wrGroup == GRP_IDX_W'(g)) |=> (selReg[g] == $past(wrData))) else $error("group write"); // R2
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    localparam int GI = c / GROUP_W;
    localparam int BI = c % GROUP_W;
    always_ff @(posedge clk) begin
      if (!rstN)             outReg[c] <= RESET_CODE;
      else if (strb.loadNow) outReg[c] <= selReg[GI][BI] ? bankB[c*DATA_W +: DATA_W]
                                                         : bankA[c*DATA_W +: DATA_W];
    end
    assign outBus[c*DATA_W +: DATA_W] = outReg[c];

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !strb.loadNow |=> $stable(outBus[c*DATA_W +: DATA_W])) else $error("hold"); // R7
  end
endmodule

// File: rtl/bank_select_load.sv
module bank_select_load
  import bsl_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 8,
  parameter int DATA_W     = 16,
  parameter int GRP_IDX_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_GROUPS*GROUP_W*DATA_W-1:0] bankAIn,
  input  logic [NUM_GROUPS*GROUP_W*DATA_W-1:0] bankBIn,
  input  logic                                 selWrEn,
  input  logic [GRP_IDX_W-1:0]                 selWrGroup,
  input  logic [GROUP_W-1:0]                   selWrData,
  input  logic                                 setAllEn,
  input  logic                                 setAllVal,
  input  logic                                 loadN,
  output logic [NUM_GROUPS*GROUP_W*DATA_W-1:0] dacOut
);
  bsl_strobe_t strb;

  bsl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .loadN(loadN), .selWrEn(selWrEn),
    .setAllEn(setAllEn), .setAllVal(setAllVal), .strb(strb)
  );

  bsl_datapath #(
    .NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .DATA_W(DATA_W), .GRP_IDX_W(GRP_IDX_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrGroup(selWrGroup), .wrData(selWrData),
    .bankA(bankAIn), .bankB(bankBIn), .outBus(dacOut)
  );
endmodule

// File: tb/bank_select_load_test.sv
module bank_select_load_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;
  localparam int DW  = 16;

  logic clk = 0;
  logic rstN = 0;
  logic [NCH*DW-1:0] bankAIn = '0, bankBIn = '0;
  logic selWrEn = 0;
  logic [1:0] selWrGroup = '0;
  logic [7:0] selWrData = '0;
  logic setAllEn = 0, setAllVal = 0, loadN = 1;
  logic [NCH*DW-1:0] dacOut;

  int checks = 0, errors = 0;
  logic [NCH-1:0] expSel = '0;
  logic [DW-1:0] expOut [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_select_load uut (
    .clk(clk), .rstN(rstN), .bankAIn(bankAIn), .bankBIn(bankBIn),
    .selWrEn(selWrEn), .selWrGroup(selWrGroup), .selWrData(selWrData),
    .setAllEn(setAllEn), .setAllVal(setAllVal), .loadN(loadN), .dacOut(dacOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setBanks(input int seed);
    for (int c = 0; c < NCH; c++) begin
      bankAIn[c*DW +: DW] = DW'(c * 16'h0203 + seed * 16'h1111 + 16'h0011);
      bankBIn[c*DW +: DW] = DW'(16'hF00F ^ (c * 16'h0405 + seed * 16'h0707));
    end
  endtask

  task automatic latchExpected();
    for (int c = 0; c < NCH; c++)
      expOut[c] = expSel[c] ? bankBIn[c*DW +: DW] : bankAIn[c*DW +: DW];
  endtask

  task automatic checkOut(input string req);
    int bad = -1;
    checks++;
    for (int c = 0; c < NCH; c++)
      if (bad < 0 && dacOut[c*DW +: DW] !== expOut[c]) bad = c;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s ch%0d actual=%h expected=%h", req, bad, dacOut[bad*DW +: DW], expOut[bad]);
    end
  endtask

  task automatic loadPulse();
    loadN = 0; tick(1); loadN = 1;
    tick(2);
  endtask

  task automatic groupWrite(input int g, input logic [7:0] d);
    selWrEn = 1; selWrGroup = 2'(g); selWrData = d; tick(1); selWrEn = 0;
    for (int k = 0; k < 8; k++) expSel[g*8+k] = d[k];
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    setBanks(1);
    tick(3);
    rstN = 1;
    tick(1);
    for (int c = 0; c < NCH; c++) expOut[c] = 16'h8000;
    checkOut("R1 reset outputs");
    // R1: select bits zero after reset -> load gives bank A
    loadPulse(); latchExpected(); checkOut("R1 R3 reset select zero");

    // R6: latency of a single-cycle load pulse
    setBanks(2);
    loadN = 0; tick(1); loadN = 1;
    tick(1); checkOut("R6 no update before second sync edge");
    tick(1); latchExpected(); checkOut("R6 update on third edge");

    // R2 R3: exhaustive sweep of every group value
    for (int g = 0; g < 4; g++)
      for (int v = 0; v < 256; v++) begin
        setBanks(v + g);
        groupWrite(g, 8'(v));
        loadPulse(); latchExpected(); checkOut("R2 R3 group sweep");
      end

    // R4: broadcast to 1 then 0
    setAllEn = 1; setAllVal = 1; tick(1); setAllEn = 0; expSel = '1;
    loadPulse(); latchExpected(); checkOut("R4 set all one");
    setAllEn = 1; setAllVal = 0; tick(1); setAllEn = 0; expSel = '0;
    loadPulse(); latchExpected(); checkOut("R4 set all zero");

    // R5: broadcast and group write in the same cycle
    setAllEn = 1; setAllVal = 1; selWrEn = 1; selWrGroup = 2; selWrData = 8'h00;
    tick(1); setAllEn = 0; selWrEn = 0; expSel = '1;
    loadPulse(); latchExpected(); checkOut("R5 broadcast wins");
    setAllEn = 1; setAllVal = 0; selWrEn = 1; selWrGroup = 1; selWrData = 8'hFF;
    tick(1); setAllEn = 0; selWrEn = 0; expSel = '0;
    loadPulse(); latchExpected(); checkOut("R5 broadcast zero wins");

    // R7: hold while load is high
    groupWrite(3, 8'hA5);
    setBanks(77);
    tick(4); checkOut("R7 hold ignores banks and selects");

    // R8: follow while held low
    loadN = 0; tick(3); latchExpected(); checkOut("R8 settle low");
    setBanks(91); tick(1); latchExpected(); checkOut("R8 follow one edge");
    setBanks(92); tick(1); latchExpected(); checkOut("R8 follow again");

    // R9: select write coincident with active load
    selWrEn = 1; selWrGroup = 0; selWrData = 8'h3C;
    latchExpected();
    tick(1); selWrEn = 0;
    checkOut("R9 old select on write edge");
    expSel[7:0] = 8'h3C;
    tick(1); latchExpected(); checkOut("R9 new select next edge");
    loadN = 1; tick(3);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule